// File: doc/BRIEF.md
# Pipelined Carry-Skip Adder/Subtractor

This block adds or subtracts two small unsigned words with a carry or borrow input. The function is selected for the whole word by one mode input. A chain of single-bit cells passes the carry or borrow from the least significant bit upwards. A block-level skip path can carry the incoming carry or borrow straight to the block output when every bit would pass it through anyway.

A pipeline register cuts the chain between two bit cells. The upper operand bits, the mode, the block carry/borrow input and the block-wide pass-through flag are captured next to the partial carry, so the second stage always completes the same operation. The low result bits are held back one extra register so that the whole result, the carry/borrow output and the valid strobe appear in the same cycle, two clock edges after the operands are presented.

A new operation can be accepted on every clock. Bubbles in the valid input show up unchanged, two cycles later, in the valid output.

Top module: `csk_addsub_pipe`

## Requirements
- R1: With `op_sub` = 0, the outputs `{cb_out, res}` equal `a + b + cb_in`, taken as a WIDTH+1 bit unsigned sum.
- R2: With `op_sub` = 1, `res` equals the low WIDTH bits of `a - b - cb_in`, and `cb_out` is 1 exactly when `a < b + cb_in` (a borrow out).
- R3: Bit n passes its carry/borrow input to its output when `a[n] ^ b[n] ^ op_sub` is 1. When this holds for every bit, `cb_out` equals the block's `cb_in`; for example a=5, b=10 in add mode, or a=b in subtract mode.
- R4: The result for operands presented before clock edge k appears on the outputs after edge k+1. Back-to-back operations produce one result per cycle.
- R5: `out_valid` reproduces `in_valid` two cycles later, including bubbles.
- R6: While `rst_n` is low, `out_valid`, `res` and `cb_out` are 0, and no valid result appears until an operation is presented after reset is released.
- R7: Each result uses the mode and carry/borrow input of its own operation, even when successive operations alternate between add and subtract.
- R8: The carry/borrow input takes effect across the whole word. Add mode with a=15, b=0, cb_in=1 gives res=0 and cb_out=1. Subtract mode with a=0, b=0, cb_in=1 gives res=15 and cb_out=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the operand inputs |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| cb_in | input | 1 | Carry-in (add) or borrow-in (subtract) |
| a | input | WIDTH | First operand / minuend |
| b | input | WIDTH | Second operand / subtrahend |
| out_valid | output | 1 | Result outputs hold a completed operation |
| res | output | WIDTH | Sum or difference |
| cb_out | output | 1 | Carry-out (add) or borrow-out (subtract) |

## Verification
The hardest case to reach is two different operations in flight at once. One operation's upper bits are being resolved in stage two while the next operation's lower bits are entering stage one, and a misaligned register would pair one operation's partial carry with the other's operands or mode. The stimulus streams operations on every cycle with random operands, random modes and random carry/borrow inputs, and checks each result exactly two cycles after issue. The vector table also alternates the mode on consecutive cycles and includes full-propagate operands, so the skip path is chosen for one operation and the ripple path for its neighbour.

// File: rtl/csk_pkg.sv
package csk_pkg;
   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } op_e;

   // carry (add) or borrow (subtract) generated by one bit without any input
   function automatic logic cell_gen(op_e op, logic a, logic b);
      return (op == OP_SUB) ? (~a & b) : (a & b);
   endfunction

   // bit passes its incoming carry/borrow through unchanged
   function automatic logic cell_prop(op_e op, logic a, logic b);
      return a ^ b ^ (op == OP_SUB);
   endfunction
endpackage

// File: rtl/csk_cell.sv
module csk_cell
   import csk_pkg::*;
(
   input  op_e  op,
   input  logic a,
   input  logic b,
   input  logic cb_in,
   output logic s,
   output logic cb_out
);
   logic g;
   logic p;

   always_comb begin
      g      = cell_gen(op, a, b);
      p      = cell_prop(op, a, b);
      s      = a ^ b ^ cb_in;
      cb_out = g | (p & cb_in);
   end
endmodule

// File: rtl/csk_ripple.sv
module csk_ripple
   import csk_pkg::*;
#(
   parameter int N = 2
) (
   input  op_e          op,
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic         cb_in,
   output logic [N-1:0] s,
   output logic         cb_out
);
   logic [N:0] chain;

   assign chain[0] = cb_in;

   for (genvar i = 0; i < N; i++) begin : g_bit
      csk_cell u_cell (
         .op     (op),
         .a      (a[i]),
         .b      (b[i]),
         .cb_in  (chain[i]),
         .s      (s[i]),
         .cb_out (chain[i+1])
      );
   end

   assign cb_out = chain[N];
endmodule

// File: rtl/csk_addsub_pipe.sv
module csk_addsub_pipe
   import csk_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter int SPLIT       = 2,
   parameter bit ENABLE_SKIP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             op_sub,
   input  logic             cb_in,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic             out_valid,
   output logic [WIDTH-1:0] res,
   output logic             cb_out
);
   localparam int LO_W = SPLIT;
   localparam int HI_W = WIDTH - SPLIT;

   if (WIDTH < 2) begin : g_bad_width
      $error("csk_addsub_pipe: WIDTH must be at least 2");
   end
   if (SPLIT < 1 || SPLIT > WIDTH - 1) begin : g_bad_split
      $error("csk_addsub_pipe: SPLIT must lie in 1..WIDTH-1");
   end

   // ---------------- stage 1: lower bits and block propagate ----------------
   op_e             op_in;
   logic [LO_W-1:0] lo_sum;
   logic            lo_cbo;
   logic [WIDTH-1:0] bit_prop;
   logic            blk_prop;

   assign op_in = op_e'(op_sub);

   csk_ripple #(.N(LO_W)) u_lo (
      .op     (op_in),
      .a      (a[LO_W-1:0]),
      .b      (b[LO_W-1:0]),
      .cb_in  (cb_in),
      .s      (lo_sum),
      .cb_out (lo_cbo)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_prop
      assign bit_prop[i] = cell_prop(op_in, a[i], b[i]);
   end
   assign blk_prop = &bit_prop;

   logic            s1_valid;
   op_e             s1_op;
   logic            s1_blk_cbi;
   logic            s1_mid_cb;
   logic            s1_bp;
   logic [LO_W-1:0] s1_lo_sum;
   logic [HI_W-1:0] s1_a_hi;
   logic [HI_W-1:0] s1_b_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid   <= 1'b0;
         s1_op      <= OP_ADD;
         s1_blk_cbi <= 1'b0;
         s1_mid_cb  <= 1'b0;
         s1_bp      <= 1'b0;
         s1_lo_sum  <= '0;
         s1_a_hi    <= '0;
         s1_b_hi    <= '0;
      end else begin
         s1_valid   <= in_valid;
         s1_op      <= op_in;
         s1_blk_cbi <= cb_in;
         s1_mid_cb  <= lo_cbo;
         s1_bp      <= blk_prop;
         s1_lo_sum  <= lo_sum;
         s1_a_hi    <= a[WIDTH-1:SPLIT];
         s1_b_hi    <= b[WIDTH-1:SPLIT];
      end
   end

   // ---------------- stage 2: upper bits and skip selection ----------------
   logic [HI_W-1:0] hi_sum;
   logic            hi_cbo;
   logic            blk_cbo;

   csk_ripple #(.N(HI_W)) u_hi (
      .op     (s1_op),
      .a      (s1_a_hi),
      .b      (s1_b_hi),
      .cb_in  (s1_mid_cb),
      .s      (hi_sum),
      .cb_out (hi_cbo)
   );

   if (ENABLE_SKIP) begin : g_skip
      assign blk_cbo = s1_bp ? s1_blk_cbi : hi_cbo;
   end else begin : g_ripple_only
      assign blk_cbo = hi_cbo;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res       <= '0;
         cb_out    <= 1'b0;
      end else begin
         out_valid <= s1_valid;
         res       <= {hi_sum, s1_lo_sum};
         cb_out    <= blk_cbo;
      end
   end
endmodule

// File: rtl/csk_addsub_chk.sv
module csk_addsub_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             op_sub,
   input logic             cb_in,
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic             out_valid,
   input logic [WIDTH-1:0] res,
   input logic             cb_out
);
   logic [WIDTH:0] e_now;
   logic           e_skip;

   always_comb begin
      if (op_sub)
         e_now = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, cb_in};
      else
         e_now = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cb_in};
      e_skip = &(a ^ b ^ {WIDTH{op_sub}});
   end

   logic [1:0]     q_valid, q_op, q_skip, q_cin;
   logic [WIDTH:0] q1_val, q2_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= '0;
         q_op    <= '0;
         q_skip  <= '0;
         q_cin   <= '0;
         q1_val  <= '0;
         q2_val  <= '0;
      end else begin
         q_valid <= {q_valid[0], in_valid};
         q_op    <= {q_op[0], op_sub};
         q_skip  <= {q_skip[0], e_skip};
         q_cin   <= {q_cin[0], cb_in};
         q1_val  <= e_now;
         q2_val  <= q1_val;
      end
   end

   AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !q_op[1]) |-> ({cb_out, res} == q2_val)); // R1

   AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && q_op[1]) |-> ({cb_out, res} == q2_val)); // R2

   AST_SKIP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && q_skip[1]) |-> (cb_out == q_cin[1])); // R3

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == q_valid[1]); // R5

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && res == '0 && !cb_out)); // R6
endmodule

bind csk_addsub_pipe csk_addsub_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_sub    (op_sub),
   .cb_in     (cb_in),
   .a         (a),
   .b         (b),
   .out_valid (out_valid),
   .res       (res),
   .cb_out    (cb_out)
);

// File: tb/sim_csk_addsub_pipe.sv
module sim_csk_addsub_pipe;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 4;
   localparam int NVEC       = 12;
   localparam int NRAND      = 200;

   // {op_sub, cb_in, a[3:0], b[3:0], cb_out, res[3:0]}
   localparam logic [14:0] VEC [NVEC] = '{
      15'b0_0_0011_0100_0_0111,  // R1  3+4+0 = 7
      15'b1_0_1001_0011_0_0110,  // R2  9-3-0 = 6 (mode alternates, R7)
      15'b0_1_1001_1000_1_0010,  // R1  9+8+1 = 18
      15'b1_0_0011_1001_1_1010,  // R2  3-9 wraps, borrow
      15'b0_1_1111_0000_1_0000,  // R8  15+0+1, skip path
      15'b1_1_0000_0000_1_1111,  // R8  0-0-1, skip path
      15'b0_0_0101_1010_0_1111,  // R3  all propagate, cin 0
      15'b1_0_0111_0111_0_0000,  // R3  a==b subtract, bin 0
      15'b1_1_1100_0101_0_0110,  // R2  12-5-1 = 6
      15'b0_1_1111_1111_1_1111,  // R1  15+15+1 = 31
      15'b1_1_0110_1000_1_1101,  // R2  6-8-1 wraps
      15'b0_0_1100_0011_0_1111   // R3  12+3, skip with cin 0
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         op_sub = 1'b0;
   logic         cb_in = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic         out_valid;
   logic [W-1:0] res;
   logic         cb_out;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   csk_addsub_pipe #(.WIDTH(W), .SPLIT(2), .ENABLE_SKIP(1'b1)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op_sub    (op_sub),
      .cb_in     (cb_in),
      .a         (a),
      .b         (b),
      .out_valid (out_valid),
      .res       (res),
      .cb_out    (cb_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [W:0] model(logic s, logic c, logic [W-1:0] x, logic [W-1:0] y);
      if (s) return {1'b0, x} - {1'b0, y} - {{W{1'b0}}, c};
      return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
   endfunction

   task automatic drive(input logic v, input logic s, input logic c,
                        input logic [W-1:0] x, input logic [W-1:0] y);
      in_valid = v;
      op_sub   = s;
      cb_in    = c;
      a        = x;
      b        = y;
   endtask

   // one isolated operation, sampled two edges after issue
   task automatic run_one(input logic s, input logic c, input logic [W-1:0] x,
                          input logic [W-1:0] y, input string req);
      logic [W:0] e;
      e = model(s, c, x, y);
      @(negedge clk);
      drive(1'b1, s, c, x, y);
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b0, '0, '0);
      @(negedge clk);
      check(out_valid === 1'b1, req, int'(out_valid), 1);
      check({cb_out, res} === e, req, int'({cb_out, res}), int'(e));
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin : main
      logic [W:0] exp_q [NRAND];
      logic [4:0] pat;

      // reset state, R6
      repeat (3) @(negedge clk);
      check(out_valid === 1'b0 && res === '0 && cb_out === 1'b0, "R6 in reset",
            int'({out_valid, cb_out, res}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(out_valid === 1'b0, "R6 idle after release", int'(out_valid), 0);

      // table walk, back-to-back (R1 R2 R3 R7 R8)
      for (int i = 0; i < NVEC + 2; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            check(out_valid === 1'b1, VEC[i-2][14] ? "R2 valid" : "R1 valid",
                  int'(out_valid), 1);
            check({cb_out, res} === VEC[i-2][4:0],
                  VEC[i-2][14] ? "R2/R7 table result" : "R1/R7 table result",
                  int'({cb_out, res}), int'(VEC[i-2][4:0]));
         end
         if (i < NVEC)
            drive(1'b1, VEC[i][14], VEC[i][13], VEC[i][12:9], VEC[i][8:5]);
         else
            drive(1'b0, 1'b0, 1'b0, '0, '0);
      end

      // directed skip and carry/borrow-in cases
      run_one(1'b0, 1'b1, 4'd5, 4'd10, "R3 add skip cin=1");
      run_one(1'b1, 1'b1, 4'd9, 4'd9, "R3 sub skip bin=1");
      run_one(1'b0, 1'b1, 4'd15, 4'd0, "R8 carry ripples full word");
      run_one(1'b1, 1'b1, 4'd0, 4'd0, "R8 borrow wraps full word");

      // random back-to-back stream, R4 and R7
      for (int i = 0; i < NRAND + 2; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            check(out_valid === 1'b1, "R4 stream valid", int'(out_valid), 1);
            check({cb_out, res} === exp_q[i-2], "R4 stream result",
                  int'({cb_out, res}), int'(exp_q[i-2]));
         end
         if (i < NRAND) begin
            logic s, c;
            logic [W-1:0] x, y;
            s = 1'($urandom);
            c = 1'($urandom);
            x = W'($urandom);
            y = W'($urandom);
            exp_q[i] = model(s, c, x, y);
            drive(1'b1, s, c, x, y);
         end else begin
            drive(1'b0, 1'b0, 1'b0, '0, '0);
         end
      end

      // bubble pattern, R5
      pat = 5'b01101;
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         if (i >= 2)
            check(out_valid === pat[i-2], "R5 bubble", int'(out_valid), int'(pat[i-2]));
         if (i < 5)
            drive(pat[i], 1'b0, 1'b1, 4'd3, 4'd3);
         else
            drive(1'b0, 1'b0, 1'b0, '0, '0);
      end

      // reset during a stream, R6
      @(negedge clk);
      drive(1'b1, 1'b0, 1'b1, 4'd7, 4'd6);
      @(negedge clk);
      drive(1'b1, 1'b1, 1'b0, 4'd2, 4'd9);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(out_valid === 1'b0 && res === '0 && cb_out === 1'b0, "R6 async clear",
            int'({out_valid, cb_out, res}), 0);
      drive(1'b0, 1'b0, 1'b0, '0, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(out_valid === 1'b0, "R6 no stale result", int'(out_valid), 0);
      run_one(1'b1, 1'b0, 4'd10, 4'd4, "R2 after reset");

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule